// File: doc/BRIEF.md
# Mersenne-prime modular feedback LFSR

This block is a sixteen-stage shift register whose cells are 31 bits wide and whose feedback word is formed by arithmetic modulo the Mersenne prime 2^31-1 rather than by XOR over GF(2). Five of the cells are each rotated within their own 31 bits and added together with one unrotated copy of cell 0. The sum, reduced modulo 2^31-1, becomes the new top cell while every other cell moves down by one position.

Two operating modes exist. In init mode an external 31-bit word is folded into the modular sum before it is stored. In work mode that word is not used. Because zero is not a legal cell value, a feedback result of zero is stored as 2^31-1. The whole register can be written in parallel from outside, and every cell can be read in parallel at all times. One asserted step cycle advances the register by exactly one position, and the feedback path is combinational.

Top module: `mersenne_lfsr`

## Requirements
- R1: While rst_ni is low, and after reset is released with no load or step, every cell reads 2^31-1 (all ones).
- R2: When load_i is high at a clock edge, all 16 cells take the value on load_cells_i on that edge, whatever step_i is. Cell k occupies bits [31k+30:31k] of load_cells_i and of cells_o.
- R3: With load_i and step_i both low, no cell changes.
- R4: On a step edge (step_i high, load_i low), cell k takes the old value of cell k+1 for k = 0 to 14.
- R5: On a step edge in work mode (init_mode_i low), cell 15 takes v = (s15 rotl 15) + (s13 rotl 17) + (s10 rotl 21) + (s4 rotl 20) + (s0 rotl 8) + s0 modulo 2^31-1, where rotl is a cyclic left rotation within 31 bits and s are the old cell values.
- R6: On a step edge in init mode (init_mode_i high), cell 15 takes v + word_i modulo 2^31-1.
- R7: A new cell 15 value that would be 0 is stored as 2^31-1; a stepped cell 15 is never zero.
- R8: In work mode word_i has no effect on any cell.
- R9: The register advances by one position for each cycle in which step_i is high, the result being visible on cells_o right after that clock edge, and not at all in cycles where step_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Parallel load strobe, has priority over step |
| load_cells_i | input | 496 | Values for all 16 cells, cell k at bits [31k+30:31k] |
| step_i | input | 1 | Advance by one position |
| init_mode_i | input | 1 | 1 selects init mode (fold in word_i), 0 selects work mode |
| word_i | input | 31 | External word added in init mode |
| cells_o | output | 496 | All 16 cells, cell k at bits [31k+30:31k] |

## Verification
The zero substitution is the hardest case to reach: the modular adder chain only yields an exact zero when every operand is zero, and a register fed only by legal nonzero values never gets there. The bench reaches it by parallel-loading zeros into the five tap cells (s0, s4, s10, s13, s15) while leaving the other cells nonzero, then stepping in work mode and in init mode with a zero input word. Long runs of random steps in both modes are compared against a bench model that reduces with a plain integer remainder, so the wrap-around behaviour of the carry-folding adder is covered without targeting it.

// File: rtl/mfsr_pkg.sv
`timescale 1ns/1ps
package mfsr_pkg;
  localparam int CELL_W    = 31;
  localparam int NUM_CELLS = 16;
  localparam int NUM_TAPS  = 5;
  // rotated taps + unrotated s0 + external word
  localparam int NUM_TERMS = NUM_TAPS + 2;
  localparam int TREE_LVLS = $clog2(NUM_TERMS);
  localparam int TREE_PAD  = 1 << TREE_LVLS;

  typedef logic [CELL_W-1:0] cell_t;

  localparam cell_t CELL_MAX = '1;

  localparam int TAP_IDX [NUM_TAPS] = '{15, 13, 10, 4, 0};
  localparam int TAP_ROT [NUM_TAPS] = '{15, 17, 21, 20, 8};

  function automatic cell_t rotl(cell_t x, int unsigned amt);
    logic [2*CELL_W-1:0] d;
    d = {x, x} << amt;
    return d[2*CELL_W-1 -: CELL_W];
  endfunction
endpackage

// File: rtl/mfsr_mod_add.sv
`timescale 1ns/1ps
module mfsr_mod_add #(
  parameter int W = 31
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] raw;

  // end-around carry: constant-time reduction modulo 2^W-1
  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i};
    sum_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end
endmodule

// File: rtl/mfsr_feedback.sv
`timescale 1ns/1ps
module mfsr_feedback
  import mfsr_pkg::*;
(
  input  cell_t cells_i [NUM_CELLS],
  input  logic  init_mode_i,
  input  cell_t word_i,
  output cell_t next_o
);
  cell_t term [NUM_TERMS];
  cell_t root;

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    assign term[t] = rotl(cells_i[TAP_IDX[t]], TAP_ROT[t]);
  end
  assign term[NUM_TAPS]   = cells_i[0];
  assign term[NUM_TAPS+1] = init_mode_i ? word_i : '0;

  // balanced reduction tree, zero-padded to a power of two
  for (genvar l = 0; l <= TREE_LVLS; l++) begin : g_lvl
    cell_t v [TREE_PAD >> l];
    if (l == 0) begin : g_leaves
      for (genvar j = 0; j < TREE_PAD; j++) begin : g_leaf
        if (j < NUM_TERMS) begin : g_used
          assign v[j] = term[j];
        end else begin : g_pad
          assign v[j] = '0;
        end
      end
    end else begin : g_nodes
      for (genvar j = 0; j < (TREE_PAD >> l); j++) begin : g_node
        mfsr_mod_add #(.W(CELL_W)) u_add (
          .a_i  (g_lvl[l-1].v[2*j]),
          .b_i  (g_lvl[l-1].v[2*j+1]),
          .sum_o(v[j])
        );
      end
    end
  end

  assign root   = g_lvl[TREE_LVLS].v[0];
  // zero is illegal in a cell
  assign next_o = (root == '0) ? CELL_MAX : root;
endmodule

// File: rtl/mfsr_cell_store.sv
`timescale 1ns/1ps
module mfsr_cell_store
  import mfsr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  cell_t load_i_cells [NUM_CELLS],
  input  logic  step_i,
  input  cell_t feed_i,
  output cell_t cells_o [NUM_CELLS]
);
  cell_t cell_q [NUM_CELLS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_CELLS; k++) cell_q[k] <= CELL_MAX;
    end else if (load_i) begin
      for (int k = 0; k < NUM_CELLS; k++) cell_q[k] <= load_i_cells[k];
    end else if (step_i) begin
      for (int k = 0; k < NUM_CELLS-1; k++) cell_q[k] <= cell_q[k+1];
      cell_q[NUM_CELLS-1] <= feed_i;
    end
  end

  assign cells_o = cell_q;
endmodule

// File: rtl/mersenne_lfsr.sv
`timescale 1ns/1ps
module mersenne_lfsr
  import mfsr_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [NUM_CELLS*CELL_W-1:0]   load_cells_i,
  input  logic                          step_i,
  input  logic                          init_mode_i,
  input  logic [CELL_W-1:0]             word_i,
  output logic [NUM_CELLS*CELL_W-1:0]   cells_o
);
  cell_t ld_cells [NUM_CELLS];
  cell_t cur      [NUM_CELLS];
  cell_t feed;

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_flat
    assign ld_cells[k]               = load_cells_i[k*CELL_W +: CELL_W];
    assign cells_o[k*CELL_W +: CELL_W] = cur[k];
  end

  mfsr_feedback u_fb (
    .cells_i    (cur),
    .init_mode_i(init_mode_i),
    .word_i     (word_i),
    .next_o     (feed)
  );

  mfsr_cell_store u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_i_cells(ld_cells),
    .step_i      (step_i),
    .feed_i      (feed),
    .cells_o     (cur)
  );
endmodule

// File: rtl/mersenne_lfsr_chk.sv
`timescale 1ns/1ps
module mersenne_lfsr_chk #(
  parameter int W = 31,
  parameter int N = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           load_i,
  input logic           step_i,
  input logic [N*W-1:0] load_cells_i,
  input logic [N*W-1:0] cells_o
);
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cells_o == $past(load_cells_i));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(cells_o));

  for (genvar i = 0; i < N-1; i++) begin : g_shift
    p_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !load_i) |=> cells_o[i*W +: W] == $past(cells_o[(i+1)*W +: W]));
  end

  p_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> cells_o[(N-1)*W +: W] != '0);
endmodule

bind mersenne_lfsr mersenne_lfsr_chk #(
  .W(mfsr_pkg::CELL_W),
  .N(mfsr_pkg::NUM_CELLS)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .step_i      (step_i),
  .load_cells_i(load_cells_i),
  .cells_o     (cells_o)
);

// File: tb/mersenne_lfsr_tb_top.sv
`timescale 1ns/1ps
module mersenne_lfsr_tb_top;
  localparam int W = 31;
  localparam int N = 16;
  localparam longint P = 64'h7FFF_FFFF;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           load_i = 1'b0;
  logic [N*W-1:0] load_cells_i = '0;
  logic           step_i = 1'b0;
  logic           init_mode_i = 1'b0;
  logic [W-1:0]   word_i = '0;
  logic [N*W-1:0] cells_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [W-1:0] m [N];

  always #4 clk_i = ~clk_i;

  mersenne_lfsr dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_cells_i(load_cells_i),
    .step_i(step_i), .init_mode_i(init_mode_i), .word_i(word_i), .cells_o(cells_o)
  );

  function automatic longint rot(logic [W-1:0] x, int a);
    longint xv = longint'(x);
    return ((xv << a) | (xv >> (W - a))) & P;
  endfunction

  function automatic logic [W-1:0] model_fb(bit init, logic [W-1:0] u);
    longint s;
    s = rot(m[15], 15) + rot(m[13], 17) + rot(m[10], 21) + rot(m[4], 20)
      + rot(m[0], 8) + longint'(m[0]) + (init ? longint'(u) : 64'd0);
    s = s % P;
    if (s == 0) s = P;
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] rnd_cell();
    logic [W-1:0] r;
    r = W'($urandom);
    if (r == '0) r = 1;
    return r;
  endfunction

  task automatic cyc();
    @(posedge clk_i);
    #2;
  endtask

  task automatic check(string tag, logic [W-1:0] exp_c [N]);
    int idx = -1;
    for (int k = N-1; k >= 0; k--)
      if (cells_o[k*W +: W] !== exp_c[k]) idx = k;
    total++;
    if (idx >= 0) begin
      bad++;
      $display("FAIL %s cell %0d actual=%h expected=%h", tag, idx,
               cells_o[idx*W +: W], exp_c[idx]);
    end
  endtask

  task automatic check_one(string tag, logic [W-1:0] act, logic [W-1:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic do_load(logic [W-1:0] v [N], bit with_step);
    for (int k = 0; k < N; k++) load_cells_i[k*W +: W] = v[k];
    load_i = 1'b1;
    step_i = with_step;
    cyc();
    load_i = 1'b0;
    step_i = 1'b0;
    for (int k = 0; k < N; k++) m[k] = v[k];
  endtask

  task automatic do_step(bit init, logic [W-1:0] u);
    logic [W-1:0] nv;
    init_mode_i = init;
    word_i      = u;
    step_i      = 1'b1;
    nv = model_fb(init, u);
    cyc();
    step_i = 1'b0;
    for (int k = 0; k < N-1; k++) m[k] = m[k+1];
    m[N-1] = nv;
  endtask

  task automatic load_random();
    logic [W-1:0] v [N];
    for (int k = 0; k < N; k++) v[k] = rnd_cell();
    do_load(v, 1'b0);
  endtask

  task automatic t_reset_r1();
    logic [W-1:0] e [N];
    for (int k = 0; k < N; k++) e[k] = W'(P);
    cyc();
    check("R1 during reset", e);
    rst_ni = 1'b1;
    cyc();
    cyc();
    check("R1 after release", e);
    for (int k = 0; k < N; k++) m[k] = W'(P);
  endtask

  task automatic t_load_r2();
    load_random();
    check("R2 parallel load", m);
  endtask

  task automatic t_hold_r3();
    init_mode_i = 1'b1;
    word_i = 31'h1234567;
    for (int i = 0; i < 5; i++) cyc();
    check("R3 idle hold", m);
  endtask

  task automatic t_work_r5();
    load_random();
    for (int i = 0; i < 80; i++) begin
      do_step(1'b0, rnd_cell());
      check("R4 R5 work step", m);
    end
  endtask

  task automatic t_init_r6();
    load_random();
    for (int i = 0; i < 80; i++) begin
      do_step(1'b1, (i % 7 == 0) ? W'(P) : rnd_cell());
      check("R4 R6 init step", m);
    end
  endtask

  task automatic t_word_r8();
    logic [W-1:0] v [N];
    logic [W-1:0] first15;
    for (int k = 0; k < N; k++) v[k] = rnd_cell();
    do_load(v, 1'b0);
    do_step(1'b0, 31'h0);
    first15 = cells_o[(N-1)*W +: W];
    check("R8 work word zero", m);
    do_load(v, 1'b0);
    do_step(1'b0, 31'h5A5A5A5);
    check("R8 work word set", m);
    check_one("R8 same result", cells_o[(N-1)*W +: W], first15);
  endtask

  task automatic t_zero_r7();
    logic [W-1:0] v [N];
    for (int k = 0; k < N; k++) v[k] = rnd_cell();
    v[0] = '0; v[4] = '0; v[10] = '0; v[13] = '0; v[15] = '0;
    do_load(v, 1'b0);
    do_step(1'b0, 31'h7);
    check_one("R7 work zero substituted", cells_o[(N-1)*W +: W], W'(P));
    check("R7 work zero state", m);
    do_load(v, 1'b0);
    do_step(1'b1, 31'h0);
    check_one("R7 init zero substituted", cells_o[(N-1)*W +: W], W'(P));
  endtask

  task automatic t_prio_r2();
    logic [W-1:0] v [N];
    load_random();
    for (int k = 0; k < N; k++) v[k] = rnd_cell();
    do_load(v, 1'b1);
    check("R2 load over step", m);
  endtask

  task automatic t_gap_r9();
    bit pat [10] = '{1, 0, 1, 1, 0, 0, 1, 0, 1, 1};
    load_random();
    for (int i = 0; i < 10; i++) begin
      if (pat[i]) do_step(i[0], rnd_cell());
      else cyc();
      check("R9 strobe pattern", m);
    end
  endtask

  initial begin
    t_reset_r1();
    t_load_r2();
    t_hold_r3();
    t_work_r5();
    t_init_r6();
    t_word_r8();
    t_zero_r7();
    t_prio_r2();
    t_gap_r9();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule